// File: doc/BRIEF.md
# CSR Access Legality and Read-Modify-Write Front End

This block sits between the instruction decoder and the register file of control and status registers. For each access request it takes the 12-bit register address, the operation kind, the operand and the hart's current privilege context. In the same cycle it decides whether the access traps as an illegal instruction. It also computes the value that the back end must store. The back end supplies the current contents of the addressed register and a hit flag, and it commits the merged value when the write strobe is high. The old value is always handed back so that it can be written to the destination register.

The address itself carries the access rules. The top two bits mark a read-only register, and the next two bits give the lowest privilege level that may touch it. In supervisor mode without virtualization, with the hypervisor present, the hart acts one level higher than its nominal privilege, so it can reach the hypervisor range. The address-translation register has its own filter. It can trap when the trap-virtual-memory control is set, it drops writes that select an unsupported translation mode or that change nothing, and it raises a one-cycle flush pulse when the address-space identifier changes.

Top module: `csr_access_unit`

## Requirements
- R1: An address with bits 11:10 equal to 2'b11 is read-only. An access to it whose write mask is nonzero is illegal. A set or clear with operand zero has a zero mask and stays legal.
- R2: Privilege is encoded U=0, S=1, M=3. The access is illegal when the effective privilege is below address bits 9:8, unless `dbg_i` is high.
- R3: When `hyp_i` is high, `priv_i` is S and `virt_i` is low, the effective privilege is 2. Otherwise it equals `priv_i`.
- R4: `op_i` encodes 0 read (mask 0), 1 write (data operand, mask all-ones), 2 set (data all-ones, mask operand), 3 clear (data zero, mask operand). `wdata_o` is (old AND NOT mask) OR (data AND mask).
- R5: `we_o` is high only for a legal request with a nonzero mask. `rd_o` always returns `rdata_i`.
- R6: The access is illegal when `hit_i` is low. It is illegal in the range where bits 9:8 equal 1 when `sup_i` is low. In the range where bits 9:8 equal 2 it is illegal unless `sup_i` and `hyp_i` are both high and the hart is in M mode or in non-virtualized S mode. `dbg_i` does not lift these rules.
- R7: Any access to the translation register (address 12'h180) is illegal when `priv_i` is S and `tvm_i` is high.
- R8: A write to the translation register is committed only if the merged value differs from the old value and its mode field is valid. With XLEN=64 the mode field is bits 63:60 and the valid values are 0, 8, 9 and 10. With XLEN=32 the mode field is bit 31 and both of its values are valid.
- R9: `flush_o` pulses for one cycle after a committed translation-register write that changes the ASID field (bits 59:44 at XLEN=64, bits 30:22 at XLEN=32). No other event raises it.
- R10: `illegal_o` is combinational, valid in the request cycle, and blocks `we_o` whenever it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request valid |
| addr_i | input | 12 | Register address |
| op_i | input | 2 | Operation kind |
| operand_i | input | XLEN | Source operand |
| priv_i | input | 2 | Current privilege level |
| virt_i | input | 1 | Hart runs virtualized |
| hyp_i | input | 1 | Hypervisor extension present |
| sup_i | input | 1 | Supervisor extension present |
| dbg_i | input | 1 | Access comes from the debugger |
| tvm_i | input | 1 | Trap-virtual-memory control bit |
| hit_i | input | 1 | Back end implements this address |
| rdata_i | input | XLEN | Current register contents from the back end |
| rd_o | output | XLEN | Old value returned to the hart |
| wdata_o | output | XLEN | Merged value to store |
| we_o | output | 1 | Store strobe |
| illegal_o | output | 1 | Illegal-instruction indication |
| flush_o | output | 1 | Translation flush pulse |

## Verification
Several rules can act on one request in the same cycle. The sharpest cases are a debugger access that clears the privilege check while it breaks the read-only rule, and a translation-register write that changes the ASID while the trap-virtual-memory control is set. A full sweep covers every address range, privilege, mode flag, operation and both a zero and a nonzero operand. From that sweep the bench predicts the trap, the strobe and the merged value. For the translation register, directed cases put the TVM trap and an ASID change in the same request. The bench then expects no strobe in that cycle and no flush pulse in the next.

// File: rtl/csr_pkg.sv
package csr_pkg;
  typedef enum logic [1:0] {
    CSR_OP_READ  = 2'd0,
    CSR_OP_WRITE = 2'd1,
    CSR_OP_SET   = 2'd2,
    CSR_OP_CLEAR = 2'd3
  } csr_op_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;
  localparam logic [1:0] RO_CODE = 2'b11;
endpackage

// File: rtl/csr_rmw.sv
module csr_rmw #(
  parameter int XLEN = 64
) (
  input  csr_pkg::csr_op_e op_i,
  input  logic [XLEN-1:0]  operand_i,
  input  logic [XLEN-1:0]  old_i,
  output logic [XLEN-1:0]  merged_o,
  output logic             mask_nz_o
);
  logic [XLEN-1:0] data, mask;

  always_comb begin
    unique case (op_i)
      csr_pkg::CSR_OP_WRITE: begin data = operand_i;    mask = '1;        end
      csr_pkg::CSR_OP_SET:   begin data = '1;           mask = operand_i; end
      csr_pkg::CSR_OP_CLEAR: begin data = '0;           mask = operand_i; end
      default:               begin data = '0;           mask = '0;        end
    endcase
  end

  assign merged_o  = (old_i & ~mask) | (data & mask);
  assign mask_nz_o = |mask;
endmodule

// File: rtl/csr_priv_chk.sv
module csr_priv_chk #(
  parameter logic [11:0] ATP_ADDR = 12'h180
) (
  input  logic [11:0] addr_i,
  input  logic        mask_nz_i,
  input  logic [1:0]  priv_i,
  input  logic        virt_i,
  input  logic        hyp_i,
  input  logic        sup_i,
  input  logic        dbg_i,
  input  logic        tvm_i,
  input  logic        hit_i,
  output logic        is_atp_o,
  output logic        illegal_o
);
  import csr_pkg::*;

  logic [1:0] eff_priv, min_priv;
  logic       ro_viol, priv_viol, pred_fail, tvm_trap, hs_mode;

  assign hs_mode  = (priv_i == PRIV_S) && !virt_i;
  // HS mode reaches the hypervisor range
  assign eff_priv = (hyp_i && hs_mode) ? 2'd2 : priv_i;
  assign min_priv = addr_i[9:8];

  assign ro_viol   = (addr_i[11:10] == RO_CODE) && mask_nz_i;
  assign priv_viol = !dbg_i && (eff_priv < min_priv);

  always_comb begin
    unique case (min_priv)
      2'd1:    pred_fail = !sup_i;
      2'd2:    pred_fail = !(sup_i && hyp_i && (hs_mode || priv_i == PRIV_M));
      default: pred_fail = 1'b0;
    endcase
  end

  assign is_atp_o  = (addr_i == ATP_ADDR);
  assign tvm_trap  = is_atp_o && tvm_i && (priv_i == PRIV_S);
  assign illegal_o = ro_viol || priv_viol || pred_fail || tvm_trap || !hit_i;
endmodule

// File: rtl/csr_atp_filter.sv
module csr_atp_filter #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] merged_i,
  output logic            apply_o,
  output logic            asid_chg_o
);
  logic mode_ok;

  generate
    if (XLEN == 32) begin : g_rv32
      localparam int ASID_HI = 30;
      localparam int ASID_LO = 22;
      assign mode_ok    = 1'b1;
      assign asid_chg_o = merged_i[ASID_HI:ASID_LO] != old_i[ASID_HI:ASID_LO];
    end else begin : g_rv64
      localparam int MODE_HI = 63;
      localparam int MODE_LO = 60;
      localparam int ASID_HI = 59;
      localparam int ASID_LO = 44;
      logic [3:0] mode;
      assign mode       = merged_i[MODE_HI:MODE_LO];
      assign mode_ok    = (mode == 4'd0) || (mode == 4'd8) ||
                          (mode == 4'd9) || (mode == 4'd10);
      assign asid_chg_o = merged_i[ASID_HI:ASID_LO] != old_i[ASID_HI:ASID_LO];
    end
  endgenerate

  // mode, ASID and PPN span the whole register
  assign apply_o = mode_ok && (merged_i != old_i);
endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit #(
  parameter int          XLEN     = 64,
  parameter logic [11:0] ATP_ADDR = 12'h180
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [11:0]     addr_i,
  input  logic [1:0]      op_i,
  input  logic [XLEN-1:0] operand_i,
  input  logic [1:0]      priv_i,
  input  logic            virt_i,
  input  logic            hyp_i,
  input  logic            sup_i,
  input  logic            dbg_i,
  input  logic            tvm_i,
  input  logic            hit_i,
  input  logic [XLEN-1:0] rdata_i,
  output logic [XLEN-1:0] rd_o,
  output logic [XLEN-1:0] wdata_o,
  output logic            we_o,
  output logic            illegal_o,
  output logic            flush_o
);
  logic mask_nz, chk_illegal, is_atp, atp_apply, asid_chg, flush_q;

  csr_rmw #(.XLEN(XLEN)) u_rmw (
    .op_i      (csr_pkg::csr_op_e'(op_i)),
    .operand_i (operand_i),
    .old_i     (rdata_i),
    .merged_o  (wdata_o),
    .mask_nz_o (mask_nz)
  );

  csr_priv_chk #(.ATP_ADDR(ATP_ADDR)) u_chk (
    .addr_i    (addr_i),
    .mask_nz_i (mask_nz),
    .priv_i    (priv_i),
    .virt_i    (virt_i),
    .hyp_i     (hyp_i),
    .sup_i     (sup_i),
    .dbg_i     (dbg_i),
    .tvm_i     (tvm_i),
    .hit_i     (hit_i),
    .is_atp_o  (is_atp),
    .illegal_o (chk_illegal)
  );

  csr_atp_filter #(.XLEN(XLEN)) u_atp (
    .old_i      (rdata_i),
    .merged_i   (wdata_o),
    .apply_o    (atp_apply),
    .asid_chg_o (asid_chg)
  );

  assign rd_o      = rdata_i;
  assign illegal_o = req_i && chk_illegal;
  assign we_o      = req_i && !chk_illegal && mask_nz && (!is_atp || atp_apply);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_q <= 1'b0;
    else         flush_q <= we_o && is_atp && asid_chg;
  end

  assign flush_o = flush_q;
endmodule

// File: rtl/csr_access_unit_chk.sv
module csr_access_unit_chk #(
  parameter int          XLEN     = 64,
  parameter logic [11:0] ATP_ADDR = 12'h180
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic [11:0]     addr_i,
  input logic [1:0]      op_i,
  input logic [XLEN-1:0] operand_i,
  input logic [1:0]      priv_i,
  input logic            dbg_i,
  input logic            tvm_i,
  input logic [XLEN-1:0] rd_o,
  input logic [XLEN-1:0] wdata_o,
  input logic            we_o,
  input logic            illegal_o,
  input logic            flush_o
);
  AST_NO_WE_ON_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !we_o); // R10
  AST_RO_WRITE_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[11:10] == 2'b11 && op_i == 2'd1) |-> illegal_o); // R1
  AST_U_MACHINE_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !dbg_i && priv_i == 2'd0 && addr_i[9:8] == 2'd3) |-> illegal_o); // R2
  AST_READ_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == 2'd0) |-> !we_o); // R5
  AST_SET_MERGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && op_i == 2'd2) |-> wdata_o == (rd_o | operand_i)); // R4
  AST_CLR_MERGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && op_i == 2'd3) |-> wdata_o == (rd_o & ~operand_i)); // R4
  AST_TVM_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i == ATP_ADDR && priv_i == 2'd1 && tvm_i) |-> illegal_o); // R7
  AST_FLUSH_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(we_o && addr_i == ATP_ADDR)); // R9
endmodule

bind csr_access_unit csr_access_unit_chk #(.XLEN(XLEN), .ATP_ADDR(ATP_ADDR)) u_csr_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .addr_i    (addr_i),
  .op_i      (op_i),
  .operand_i (operand_i),
  .priv_i    (priv_i),
  .dbg_i     (dbg_i),
  .tvm_i     (tvm_i),
  .rd_o      (rd_o),
  .wdata_o   (wdata_o),
  .we_o      (we_o),
  .illegal_o (illegal_o),
  .flush_o   (flush_o)
);

// File: tb/csr_access_unit_test.sv
`timescale 1ns/1ps
module csr_access_unit_test;
  localparam int XLEN = 64;
  localparam logic [11:0] ATP = 12'h180;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0] op = '0, priv = '0;
  logic [XLEN-1:0] operand = '0, rdata = '0;
  logic virt = 0, hyp = 0, sup = 0, dbg = 0, tvm = 0, hit = 0;
  logic [XLEN-1:0] rd, wdata;
  logic we, illegal, flush;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  csr_access_unit #(.XLEN(XLEN), .ATP_ADDR(ATP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .op_i(op),
    .operand_i(operand), .priv_i(priv), .virt_i(virt), .hyp_i(hyp),
    .sup_i(sup), .dbg_i(dbg), .tvm_i(tvm), .hit_i(hit), .rdata_i(rdata),
    .rd_o(rd), .wdata_o(wdata), .we_o(we), .illegal_o(illegal), .flush_o(flush)
  );

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // drive at negedge, check combinational result, clock once, check flush
  task automatic atp_access(input logic [1:0] p, input logic t, input logic [1:0] o,
                            input logic [XLEN-1:0] old, input logic [XLEN-1:0] opnd,
                            input logic exp_ill, input logic exp_we,
                            input logic [XLEN-1:0] exp_wd, input logic exp_fl, input string tag);
    req = 1; addr = ATP; priv = p; tvm = t; op = o; rdata = old; operand = opnd;
    virt = 0; hyp = 0; sup = 1; dbg = 0; hit = 1;
    #1;
    chk({tag, " illegal"}, XLEN'(illegal), XLEN'(exp_ill));
    chk({tag, " we"}, XLEN'(we), XLEN'(exp_we));
    if (exp_we) chk({tag, " wdata"}, wdata, exp_wd);
    @(posedge clk); #0; @(negedge clk);
    chk({tag, " flush"}, XLEN'(flush), XLEN'(exp_fl));
    req = 0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    logic [XLEN-1:0] a_val, b_val;
    repeat (3) @(negedge clk);
    chk("reset flush", XLEN'(flush), '0);
    chk("reset illegal R10", XLEN'(illegal), '0);
    chk("reset we R5", XLEN'(we), '0);
    rst_n = 1;
    @(negedge clk);

    // full sweep over ranges, contexts and operations (R1-style tags written per check)
    for (int nib = 0; nib < 16; nib++)
      for (int pi = 0; pi < 3; pi++)
        for (int fl = 0; fl < 64; fl++)
          for (int o = 0; o < 4; o++)
            for (int k = 0; k < 2; k++) begin
              logic [1:0] pv, minp, effp;
              logic [XLEN-1:0] m, d, expw;
              logic ro, pred, expi, expwe;
              pv = (pi == 2) ? 2'd3 : 2'(pi);
              req = 1; addr = {4'(nib), 8'h40}; op = 2'(o); priv = pv;
              virt = fl[0]; hyp = fl[1]; sup = fl[2]; dbg = fl[3]; tvm = fl[4]; hit = fl[5];
              operand = k ? 64'h0123_4567_89AB_CDEF : '0;
              rdata = 64'hF0F0_3C3C_A5A5_0FF0;
              case (o)
                1: begin d = operand; m = '1; end
                2: begin d = '1; m = operand; end
                3: begin d = '0; m = operand; end
                default: begin d = '0; m = '0; end
              endcase
              ro   = (addr[11:10] == 2'b11);
              minp = addr[9:8];
              effp = (hyp && pv == 2'd1 && !virt) ? 2'd2 : pv;                 // R3
              pred = (minp == 2'd1) ? sup :
                     (minp == 2'd2) ? (sup && hyp && ((pv == 2'd1 && !virt) || pv == 2'd3)) : 1'b1; // R6
              expi = (ro && m != 0) || (!dbg && effp < minp) || !hit || !pred;   // R1 R2
              expwe = !expi && (m != 0);                                           // R5
              expw = (rdata & ~m) | (d & m);                                       // R4
              #1;
              chk("R1 R2 R3 R6 illegal", XLEN'(illegal), XLEN'(expi));
              chk("R5 R10 we", XLEN'(we), XLEN'(expwe));
              chk("R5 old value", rd, rdata);
              if (expwe) chk("R4 merge", wdata, expw);
              @(negedge clk);
            end
    req = 0;
    @(negedge clk);
    chk("R9 no flush after sweep", XLEN'(flush), '0);

    a_val = {4'h8, 16'h0005, 44'h0_0000_0123};
    b_val = {4'h8, 16'h0005, 44'h0_0000_0456};
    // R8 R9: valid change of ASID commits and flushes
    atp_access(2'd3, 0, 2'd1, '0, a_val, 0, 1, a_val, 1, "R8 R9 asid write");
    // R8: identical value dropped
    atp_access(2'd3, 0, 2'd1, a_val, a_val, 0, 0, '0, 0, "R8 same value");
    // R8: unsupported mode 1 dropped
    atp_access(2'd3, 0, 2'd1, '0, {4'h1, 60'h5}, 0, 0, '0, 0, "R8 bad mode");
    // R8: Sv57 mode accepted, ASID unchanged (zero) so no flush
    atp_access(2'd3, 0, 2'd1, '0, {4'hA, 60'h7}, 0, 1, {4'hA, 60'h7}, 0, "R8 R9 mode10");
    // R9: only PPN changes, no flush
    atp_access(2'd3, 0, 2'd1, a_val, b_val, 0, 1, b_val, 0, "R9 ppn only");
    // R4 set on translation register: set ASID bits
    atp_access(2'd3, 0, 2'd2, a_val, {4'h0, 16'h00F0, 44'h0}, 0, 1,
               a_val | {4'h0, 16'h00F0, 44'h0}, 1, "R4 R9 set asid");
    // R7: S mode with TVM traps even a read
    atp_access(2'd1, 1, 2'd0, a_val, '0, 1, 0, '0, 0, "R7 tvm read");
    // R7 R10: TVM trap coinciding with ASID-changing write
    atp_access(2'd1, 1, 2'd1, '0, a_val, 1, 0, '0, 0, "R7 R10 tvm write");
    // R7: M mode ignores TVM
    atp_access(2'd3, 1, 2'd1, '0, a_val, 0, 1, a_val, 1, "R7 m mode tvm");
    // R7: S mode without TVM is legal
    atp_access(2'd1, 0, 2'd1, '0, a_val, 0, 1, a_val, 1, "R7 s mode no tvm");

    finish_run();
  end
endmodule